// File: doc/BRIEF.md
# Dual-Rate Clock Recovery Lock Supervisor

This block is the digital supervisor that sits beside the analog loop of a SONET/SDH clock and data recovery front end running at either 622.08 Mb/s or 155.52 Mb/s. It receives the 19.44 MHz reference clock and the recovered line clock. It measures how many recovered-clock cycles fall inside a fixed window of reference cycles, and it reports lock only while that count matches the nominal ratio within 500 ppm.

The block also merges an optical signal-detect input, an active-low lock-to-reference request and a production-test bypass into one operating mode. That mode decides whether the data output is forced low and which clock is driven to the clock output. In bypass the reference clock is inverted onto the clock output, and data is retimed on the reference rising edge. Bypass at the low line rate is not a legal setting. It is flagged, and no data passes.

Top module: `cdr_lock_los`

## Requirements
- R1: While rst_ni is low, lock_o, los_o, cfg_err_o and data_o are all 0.
- R2: The expected ratio is 32 recovered cycles per reference cycle when rate_hi_i=1 and 8 when rate_hi_i=0. A recovered clock at exactly that ratio ends with lock_o=1.
- R3: With window W=2^WIN_LOG2 reference cycles and E=ratio*W, a window count is in range when it lies within E±floor(E*500/10^6). The first out-of-range result clears lock_o, and counts inside the bound keep or regain lock.
- R4: lock_o rises only after two consecutive in-range results. The first result after reset is discarded, so lock_o cannot be 1 before the third window boundary.
- R5: With bypass_i=0, sig_det_i=0 or hold_ref_ni=0 sets los_o=1, forces data_o=0 and clears lock_o within a few reference cycles. Lock then needs two fresh in-range windows.
- R6: With bypass_i=0 and no loss of signal, data_o is data_i sampled on the recovered rising edge, and clk_o follows rec_clk_i.
- R7: With bypass_i=1 and rate_hi_i=1, los_o=0 whatever the values of sig_det_i and hold_ref_ni. clk_o is the inverse of ref_clk_i, and data_o is data_i sampled on the reference rising edge.
- R8: With bypass_i=1 and rate_hi_i=0, cfg_err_o=1, data_o=0 and los_o=0.
- R9: Lock does not depend on data transitions. A constant data_i over many thousands of bit periods keeps lock while the frequency check passes.
- R10: lock_o is 0 in either bypass setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | 19.44 MHz reference clock |
| rec_clk_i | input | 1 | Recovered line clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rate_hi_i | input | 1 | 1 selects 622.08 Mb/s, 0 selects 155.52 Mb/s |
| bypass_i | input | 1 | Production-test loop bypass |
| sig_det_i | input | 1 | Optical signal present, active high |
| hold_ref_ni | input | 1 | Active-low request to hold on the reference |
| data_i | input | 1 | Serial line data |
| data_o | output | 1 | Retimed or forced-low data |
| clk_o | output | 1 | Selected output clock |
| lock_o | output | 1 | Frequency lock indication |
| los_o | output | 1 | Loss-of-signal state |
| cfg_err_o | output | 1 | Illegal bypass and rate combination |

## Verification
A stale or miscounted window value appears on lock_o only at window boundaries. A lock register that skips the two-window rule rises one window early, and an unapplied tolerance leaves lock_o stuck after a 0.25% frequency offset for more than two windows. A wrong mode register shows within about three reference cycles of a control change, as a data_o that is not forced low, a clk_o of the wrong polarity or source, or a missing cfg_err_o.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
  typedef enum logic [1:0] {MODE_NORM, MODE_LOS, MODE_BYP, MODE_ERR} mode_e;

  function automatic int unsigned ppm_tol(input int unsigned exp_cnt, input int unsigned ppm);
    longint unsigned p;
    p = longint'(exp_cnt) * longint'(ppm);
    return int'(p / 64'd1_000_000);
  endfunction
endpackage

// File: rtl/cdr_sync.sv
module cdr_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      q_o  <= RST_VAL;
    end else begin
      s1_q <= d_i;
      q_o  <= s1_q;
    end
  end
endmodule

// File: rtl/cdr_freq_meter.sv
module cdr_freq_meter #(
  parameter int unsigned WIN_LOG2 = 14,
  parameter int unsigned CNT_W    = 21
) (
  input  logic             ref_clk_i,
  input  logic             rec_clk_i,
  input  logic             rst_ni,
  output logic             fire_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [WIN_LOG2-1:0] win_cnt;
  logic win_tgl, win_s, win_d;
  logic [CNT_W-1:0] rec_cnt, cap_cnt;
  logic cap_tgl, cap_s, cap_d, primed;

  // reference domain: window marker toggles once per window
  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_cnt <= '0;
      win_tgl <= 1'b0;
    end else begin
      win_cnt <= win_cnt + 1'b1;
      if (&win_cnt) win_tgl <= ~win_tgl;
    end
  end

  cdr_sync #(.W(1)) u_win_sync (
    .clk_i(rec_clk_i), .rst_ni(rst_ni), .d_i(win_tgl), .q_o(win_s)
  );

  // recovered domain: count cycles between markers, hand result back by toggle
  always_ff @(posedge rec_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_d   <= 1'b0;
      rec_cnt <= '0;
      cap_cnt <= '0;
      cap_tgl <= 1'b0;
    end else begin
      win_d <= win_s;
      if (win_s ^ win_d) begin
        cap_cnt <= rec_cnt;
        rec_cnt <= CNT_W'(1);
        cap_tgl <= ~cap_tgl;
      end else if (rec_cnt != '1) begin
        rec_cnt <= rec_cnt + 1'b1;
      end
    end
  end

  cdr_sync #(.W(1)) u_cap_sync (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .d_i(cap_tgl), .q_o(cap_s)
  );

  // cap_cnt is stable for a full window once the toggle is seen here
  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_d  <= 1'b0;
      primed <= 1'b0;
      fire_o <= 1'b0;
      cnt_o  <= '0;
    end else begin
      cap_d  <= cap_s;
      fire_o <= 1'b0;
      if (cap_s ^ cap_d) begin
        primed <= 1'b1;
        if (primed) begin
          fire_o <= 1'b1;
          cnt_o  <= cap_cnt;
        end
      end
    end
  end
endmodule

// File: rtl/cdr_lock_ctrl.sv
module cdr_lock_ctrl
  import cdr_pkg::*;
#(
  parameter int unsigned CNT_W  = 21,
  parameter int unsigned EXP_HI = 524288,
  parameter int unsigned EXP_LO = 131072,
  parameter int unsigned TOL_HI = 262,
  parameter int unsigned TOL_LO = 65
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rate_hi_i,
  input  logic             bypass_i,
  input  logic             sig_det_i,
  input  logic             hold_ref_ni,
  input  logic             fire_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             res_ok_o,
  output logic             lock_o,
  output logic             los_o,
  output logic             cfg_err_o,
  output logic             byp_o
);
  localparam logic [CNT_W-1:0] HI_MIN = CNT_W'(EXP_HI - TOL_HI);
  localparam logic [CNT_W-1:0] HI_MAX = CNT_W'(EXP_HI + TOL_HI);
  localparam logic [CNT_W-1:0] LO_MIN = CNT_W'(EXP_LO - TOL_LO);
  localparam logic [CNT_W-1:0] LO_MAX = CNT_W'(EXP_LO + TOL_LO);

  mode_e mode_c;
  logic  good_q;

  always_comb begin
    if (bypass_i)                        mode_c = rate_hi_i ? MODE_BYP : MODE_ERR;
    else if (!sig_det_i || !hold_ref_ni) mode_c = MODE_LOS;
    else                                 mode_c = MODE_NORM;
  end

  assign res_ok_o = rate_hi_i ? (cnt_i >= HI_MIN && cnt_i <= HI_MAX)
                              : (cnt_i >= LO_MIN && cnt_i <= LO_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_q    <= 1'b0;
      lock_o    <= 1'b0;
      los_o     <= 1'b0;
      cfg_err_o <= 1'b0;
      byp_o     <= 1'b0;
    end else begin
      los_o     <= (mode_c == MODE_LOS);
      cfg_err_o <= (mode_c == MODE_ERR);
      byp_o     <= (mode_c == MODE_BYP);
      if (mode_c != MODE_NORM) begin
        good_q <= 1'b0;
        lock_o <= 1'b0;
      end else if (fire_i) begin
        good_q <= res_ok_o;
        lock_o <= good_q && res_ok_o;
      end
    end
  end
endmodule

// File: rtl/cdr_lock_los.sv
module cdr_lock_los
  import cdr_pkg::*;
#(
  parameter int unsigned RATIO_HI = 32,
  parameter int unsigned RATIO_LO = 8,
  parameter int unsigned WIN_LOG2 = 14,
  parameter int unsigned PPM      = 500
) (
  input  logic ref_clk_i,
  input  logic rec_clk_i,
  input  logic rst_ni,
  input  logic rate_hi_i,
  input  logic bypass_i,
  input  logic sig_det_i,
  input  logic hold_ref_ni,
  input  logic data_i,
  output logic data_o,
  output logic clk_o,
  output logic lock_o,
  output logic los_o,
  output logic cfg_err_o
);
  localparam int unsigned WIN    = 1 << WIN_LOG2;
  localparam int unsigned EXP_HI = RATIO_HI * WIN;
  localparam int unsigned EXP_LO = RATIO_LO * WIN;
  localparam int unsigned TOL_HI = ppm_tol(EXP_HI, PPM);
  localparam int unsigned TOL_LO = ppm_tol(EXP_LO, PPM);
  localparam int unsigned CNT_W  = $clog2(EXP_HI * 2 + 1);

  logic byp_s, rate_s, sd_s, hr_s;
  logic fire, res_ok, byp_q;
  logic [CNT_W-1:0] win_cnt;
  logic d_rec, d_ref;

  cdr_sync #(.W(4), .RST_VAL(4'b0011)) u_ctl_sync (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .d_i   ({bypass_i, rate_hi_i, sig_det_i, hold_ref_ni}),
    .q_o   ({byp_s, rate_s, sd_s, hr_s})
  );

  cdr_freq_meter #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W)) u_meter (
    .ref_clk_i(ref_clk_i),
    .rec_clk_i(rec_clk_i),
    .rst_ni   (rst_ni),
    .fire_o   (fire),
    .cnt_o    (win_cnt)
  );

  cdr_lock_ctrl #(
    .CNT_W(CNT_W), .EXP_HI(EXP_HI), .EXP_LO(EXP_LO), .TOL_HI(TOL_HI), .TOL_LO(TOL_LO)
  ) u_ctrl (
    .clk_i      (ref_clk_i),
    .rst_ni     (rst_ni),
    .rate_hi_i  (rate_s),
    .bypass_i   (byp_s),
    .sig_det_i  (sd_s),
    .hold_ref_ni(hr_s),
    .fire_i     (fire),
    .cnt_i      (win_cnt),
    .res_ok_o   (res_ok),
    .lock_o     (lock_o),
    .los_o      (los_o),
    .cfg_err_o  (cfg_err_o),
    .byp_o      (byp_q)
  );

  always_ff @(posedge rec_clk_i or negedge rst_ni) begin
    if (!rst_ni) d_rec <= 1'b0;
    else         d_rec <= data_i;
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) d_ref <= 1'b0;
    else         d_ref <= data_i;
  end

  assign data_o = byp_q ? d_ref : ((los_o || cfg_err_o) ? 1'b0 : d_rec);
  assign clk_o  = byp_q ? ~ref_clk_i : rec_clk_i;
endmodule

// File: rtl/cdr_lock_los_chk.sv
module cdr_lock_los_chk (
  input logic ref_clk_i,
  input logic rst_ni,
  input logic lock_o,
  input logic los_o,
  input logic cfg_err_o,
  input logic data_o,
  input logic sd_s,
  input logic hr_s,
  input logic byp_s,
  input logic rate_s,
  input logic fire,
  input logic res_ok
);
  assert_loss_drops_lock_R5: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (!byp_s && (!sd_s || !hr_s)) |=> (!lock_o && los_o));

  assert_los_data_low_R5: assert property (@(negedge ref_clk_i) disable iff (!rst_ni)
    los_o |-> !data_o);

  assert_bad_window_drop_R3: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (fire && !res_ok) |=> !lock_o);

  assert_lock_rise_on_good_R4: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(fire && res_ok));

  assert_byp_no_los_R7: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (byp_s && rate_s) |=> (!los_o && !cfg_err_o));

  assert_illegal_flag_R8: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (byp_s && !rate_s) |=> (cfg_err_o && !los_o));

  assert_byp_no_lock_R10: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    byp_s |=> !lock_o);
endmodule

bind cdr_lock_los cdr_lock_los_chk u_chk (
  .ref_clk_i(ref_clk_i),
  .rst_ni   (rst_ni),
  .lock_o   (lock_o),
  .los_o    (los_o),
  .cfg_err_o(cfg_err_o),
  .data_o   (data_o),
  .sd_s     (sd_s),
  .hr_s     (hr_s),
  .byp_s    (byp_s),
  .rate_s   (rate_s),
  .fire     (fire),
  .res_ok   (res_ok)
);

// File: tb/cdr_lock_los_tb.sv
`timescale 1ps/1ps
module cdr_lock_los_tb;
  localparam int REF_HALF = 64000;
  localparam int WIN_T    = 256 * 2 * REF_HALF;

  logic ref_clk = 1'b0, rec_clk = 1'b0, rst_n = 1'b0;
  logic rate_hi = 1'b1, bypass = 1'b0, sig_det = 1'b1, hold_ref_n = 1'b1, din = 1'b1;
  logic dout, clk_out, lock, los, cfg_err;
  int   rec_per = 4000;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  cdr_lock_los #(.WIN_LOG2(8)) u_dut (
    .ref_clk_i(ref_clk), .rec_clk_i(rec_clk), .rst_ni(rst_n),
    .rate_hi_i(rate_hi), .bypass_i(bypass), .sig_det_i(sig_det),
    .hold_ref_ni(hold_ref_n), .data_i(din), .data_o(dout), .clk_o(clk_out),
    .lock_o(lock), .los_o(los), .cfg_err_o(cfg_err)
  );

  initial forever #(REF_HALF) ref_clk = ~ref_clk;
  initial forever begin
    #(rec_per / 2) rec_clk = 1'b1;
    #(rec_per - rec_per / 2) rec_clk = 1'b0;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic ref_wait(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic win_wait(input int tenths);
    #(WIN_T / 10 * tenths);
    @(negedge ref_clk);
  endtask

  task automatic t_reset;
    ref_wait(4);
    check(lock == 0, "R1", "lock in reset", lock, 0);
    check(los == 0, "R1", "los in reset", los, 0);
    check(cfg_err == 0, "R1", "err in reset", cfg_err, 0);
    check(dout == 0, "R1", "data in reset", dout, 0);
    din = 1'b0;
    ref_wait(2);
    rst_n = 1'b1;
  endtask

  task automatic t_acquire;
    win_wait(25);
    check(lock == 0, "R4", "lock before third boundary", lock, 0);
    win_wait(10);
    check(lock == 1, "R2", "lock at 32x ratio", lock, 1);
    check(lock == 1, "R9", "lock with constant data", lock, 1);
  endtask

  task automatic t_sig_loss;
    din = 1'b1;
    sig_det = 1'b0;
    ref_wait(5);
    check(los == 1, "R5", "los on signal loss", los, 1);
    check(lock == 0, "R5", "lock on signal loss", lock, 0);
    check(dout == 0, "R5", "data forced low", dout, 0);
    sig_det = 1'b1;
    ref_wait(5);
    check(los == 0, "R5", "los cleared", los, 0);
    check(dout == 1, "R6", "data passes again", dout, 1);
    check(lock == 0, "R5", "lock needs fresh windows", lock, 0);
    hold_ref_n = 1'b0;
    ref_wait(5);
    check(los == 1, "R5", "los on hold request", los, 1);
    check(dout == 0, "R5", "data low on hold", dout, 0);
    hold_ref_n = 1'b1;
    win_wait(35);
    check(lock == 1, "R5", "lock regained", lock, 1);
  endtask

  task automatic t_freq;
    rec_per = 3990;
    win_wait(25);
    check(lock == 0, "R3", "lock lost at 0.25pct", lock, 0);
    rec_per = 3999;
    win_wait(9);
    check(lock == 0, "R4", "single good window no lock", lock, 0);
    win_wait(30);
    check(lock == 1, "R3", "lock inside tolerance", lock, 1);
    rec_per = 4000;
  endtask

  task automatic t_data_norm;
    bit [7:0] pat = 8'b1011_0010;
    @(posedge rec_clk) #500;
    check(clk_out == 1, "R6", "clk high phase", clk_out, 1);
    @(negedge rec_clk) #500;
    check(clk_out == 0, "R6", "clk low phase", clk_out, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge rec_clk) din = pat[i];
      @(negedge rec_clk);
      check(dout == pat[i], "R6", "retimed data", dout, pat[i]);
    end
  endtask

  task automatic t_bypass;
    bit [3:0] pat = 4'b0110;
    bypass = 1'b1; sig_det = 1'b0; hold_ref_n = 1'b0;
    ref_wait(5);
    check(los == 0, "R7", "los ignored in bypass", los, 0);
    check(cfg_err == 0, "R7", "no err in bypass", cfg_err, 0);
    check(lock == 0, "R10", "no lock in bypass", lock, 0);
    @(posedge ref_clk) #5000;
    check(clk_out == 0, "R7", "inverted ref high", clk_out, 0);
    @(negedge ref_clk) #5000;
    check(clk_out == 1, "R7", "inverted ref low", clk_out, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge ref_clk) din = pat[i];
      @(negedge ref_clk);
      check(dout == pat[i], "R7", "ref-edge data", dout, pat[i]);
    end
    sig_det = 1'b1; hold_ref_n = 1'b1; bypass = 1'b0;
    ref_wait(5);
  endtask

  task automatic t_illegal;
    rate_hi = 1'b0; bypass = 1'b1; din = 1'b1;
    ref_wait(5);
    check(cfg_err == 1, "R8", "illegal flagged", cfg_err, 1);
    check(dout == 0, "R8", "no data in illegal", dout, 0);
    check(los == 0, "R8", "no los in illegal", los, 0);
    check(lock == 0, "R10", "no lock in illegal", lock, 0);
    bypass = 1'b0;
  endtask

  task automatic t_low_rate;
    rec_per = 16000;
    ref_wait(5);
    check(cfg_err == 0, "R8", "err cleared", cfg_err, 0);
    win_wait(35);
    check(lock == 1, "R2", "lock at 8x ratio", lock, 1);
  endtask

  initial begin
    t_reset;
    t_acquire;
    t_sig_loss;
    t_freq;
    t_data_norm;
    t_bypass;
    t_illegal;
    t_low_rate;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #760_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule